// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the register-facing front end of a three-channel interval timer. A host reaches it through an active-low chip select, separate active-low read and write strobes, a 2-bit address and an 8-bit data bus. All of these are synchronous to the system clock. Addresses 0 to 2 select a channel's count register, and address 3 selects the control register. Control writes either program a channel or take snapshots: a snapshot of the live count, a snapshot of the status, or both through a multi-channel read-back command.

Each channel keeps its own programmed access style, mode and BCD flag, and sequences two-byte transfers with separate write and read byte pointers. When a count write completes, the channel issues a one-cycle load pulse carrying the assembled 16-bit value. The counting logic sits outside this block. It receives that value and supplies the live count and output level back as plain input ports.

Top module: `timer_host_if`

## Requirements
- R1: A write or read strobe whose falling edge occurs while `cs_n` is high has no effect. Configuration, pointers, latches, load pulses and `rdata` are all unchanged.
- R2: Each falling edge of `wr_n` with `cs_n` low causes exactly one register update, however long `wr_n` stays low. A completed count write gives a `load_stb` pulse of exactly one cycle, visible in the cycle after the edge.
- R3: A control write with bits 7:6 set to channel n (0 to 2) and bits 5:4 nonzero programs that channel. Bits 5:4 are the access style (01 low only, 10 high only, 11 low then high), bits 3:1 are the mode, and bit 0 is BCD. The mode and BCD flag appear on `cfg_mode[3n+:3]` and `cfg_bcd[n]`.
- R4: In low-then-high style, the first count write stores the low byte and gives no load. The second count write gives `load_val` = {second byte, first byte}.
- R5: In low-only style one count write loads {8'h00, byte}. In high-only style one count write loads {byte, 8'h00}.
- R6: A control write with bits 5:4 = 00 snapshots that channel's live count. Reads then return the snapshot, not the live value, until all of its bytes are read: low then high in low-then-high style, and the single selected byte otherwise.
- R7: While a count or status snapshot is unread, further snapshot commands for that channel leave it unchanged.
- R8: Read-back is a control write with bits 7:6 = 11, a per-channel mask in bits 1 (channel 0), 2 (channel 1) and 3 (channel 2), bit 5 low to snapshot counts and bit 4 low to snapshot status. The status byte is {output level, 0, access[1:0], mode[2:0], bcd}.
- R9: When both a status and a count snapshot are pending, the first read returns the status and the following reads return the count.
- R10: Programming a channel resets both its write and its read byte pointers to the low byte.
- R11: With no snapshot pending, a count read returns the live count byte chosen by the access style and the read pointer. In low-then-high style the pointer alternates on every read.
- R12: After reset, `rdata` is 0, no load pulse is active, and every channel is in low-then-high style, mode 0, binary. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select: 0 to 2 channel count, 3 control |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, registered at the read strobe edge |
| live_cnt | input | 48 | Live 16-bit count of each channel, channel n at [16n+:16] |
| out_lvl | input | 3 | Present output level of each channel |
| load_stb | output | 3 | One-cycle pulse per channel when a new count is complete |
| load_val | output | 48 | Assembled count for each channel, channel n at [16n+:16] |
| cfg_mode | output | 9 | Programmed mode per channel, channel n at [3n+:3] |
| cfg_bcd | output | 3 | Programmed BCD flag per channel |

## Verification
The hardest state to reach is a channel holding a status snapshot and a count snapshot together, while repeated snapshot commands arrive and the live count keeps moving. Only a read-back command whose count and status bits are both low creates this state, and it resolves correctly only if the reads follow in the right order. The stimulus reaches it on purpose: it issues a combined read-back, changes the live input before every read, and repeats a latch command before the first snapshot is consumed. Random rounds then program random styles, modes and channels and check load values, snapshot bytes and status bytes against bench functions.

// File: rtl/timer_if_pkg.sv
package timer_if_pkg;

   // access style field of a control word (bits 5:4)
   localparam logic [1:0] ACC_SNAP  = 2'b00;
   localparam logic [1:0] ACC_LO    = 2'b01;
   localparam logic [1:0] ACC_HI    = 2'b10;
   localparam logic [1:0] ACC_LOHI  = 2'b11;

   // channel field value that marks a read-back command
   localparam logic [1:0] SEL_RDBACK = 2'b11;

   // address of the control register
   localparam logic [1:0] ADDR_CTRL = 2'b11;

   // fields of a control word
   typedef struct packed {
      logic [1:0] sel;
      logic [1:0] acc;
      logic [2:0] mode;
      logic       bcd;
   } ctrl_word_t;

endpackage

// File: rtl/timer_strobe_edge.sv
module timer_strobe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   input  logic cs_n,
   output logic fall
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= strobe_n;
   end

   assign fall = prev_q & ~strobe_n & ~cs_n;

   // R2
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/timer_ctrl_decode.sv
module timer_ctrl_decode #(
   parameter int NCH = 3
) (
   input  logic           cw_stb,
   input  logic [7:0]     din,
   output logic [NCH-1:0] prog,
   output logic [NCH-1:0] snap_cnt,
   output logic [NCH-1:0] snap_sts
);
   import timer_if_pkg::*;

   ctrl_word_t cw;
   logic       is_rb;

   assign cw    = ctrl_word_t'(din);
   assign is_rb = (cw.sel == SEL_RDBACK);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel_me;
      logic in_mask;
      assign sel_me      = !is_rb && (cw.sel == 2'(i));
      assign in_mask     = is_rb && din[1+i];
      assign prog[i]     = cw_stb && sel_me && (cw.acc != ACC_SNAP);
      assign snap_cnt[i] = cw_stb && ((sel_me && cw.acc == ACC_SNAP) ||
                                      (in_mask && !din[5]));
      assign snap_sts[i] = cw_stb && in_mask && !din[4];
   end

endmodule

// File: rtl/timer_chan_regs.sv
module timer_chan_regs #(
   parameter int DW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_hit,
   input  logic            rd_hit,
   input  logic            prog,
   input  logic            snap_cnt,
   input  logic            snap_sts,
   input  logic [DW-1:0]   din,
   input  logic [2*DW-1:0] live,
   input  logic            out_lvl,
   output logic [DW-1:0]   rd_byte,
   output logic            load_stb,
   output logic [2*DW-1:0] load_val,
   output logic [2:0]      cfg_mode,
   output logic            cfg_bcd
);
   import timer_if_pkg::*;

   localparam int CW = 2 * DW;

   logic [1:0]    acc_q;
   logic [2:0]    mode_q;
   logic          bcd_q;
   logic          wr_ptr;
   logic          rd_ptr;
   logic [DW-1:0] low_q;
   logic          cnt_pend;
   logic [CW-1:0] cnt_hold;
   logic          sts_pend;
   logic [DW-1:0] sts_hold;
   logic [DW-1:0] sts_now;
   logic [CW-1:0] src;
   logic          last_byte;

   assign sts_now   = {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
   assign src       = cnt_pend ? cnt_hold : live;
   assign last_byte = (acc_q != ACC_LOHI) || rd_ptr;
   assign cfg_mode  = mode_q;
   assign cfg_bcd   = bcd_q;

   always_comb begin
      if (sts_pend) begin
         rd_byte = sts_hold;
      end else begin
         unique case (acc_q)
            ACC_LO:  rd_byte = src[DW-1:0];
            ACC_HI:  rd_byte = src[CW-1:DW];
            default: rd_byte = rd_ptr ? src[CW-1:DW] : src[DW-1:0];
         endcase
      end
   end

   // configuration and pointers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= ACC_LOHI;
         mode_q   <= '0;
         bcd_q    <= 1'b0;
         wr_ptr   <= 1'b0;
         rd_ptr   <= 1'b0;
         low_q    <= '0;
         load_stb <= 1'b0;
         load_val <= '0;
      end else begin
         load_stb <= 1'b0;
         if (wr_hit) begin
            unique case (acc_q)
               ACC_LO: begin
                  load_stb <= 1'b1;
                  load_val <= {{DW{1'b0}}, din};
               end
               ACC_HI: begin
                  load_stb <= 1'b1;
                  load_val <= {din, {DW{1'b0}}};
               end
               default: begin
                  if (!wr_ptr) begin
                     low_q  <= din;
                     wr_ptr <= 1'b1;
                  end else begin
                     load_stb <= 1'b1;
                     load_val <= {din, low_q};
                     wr_ptr   <= 1'b0;
                  end
               end
            endcase
         end
         if (rd_hit && !sts_pend && acc_q == ACC_LOHI)
            rd_ptr <= ~rd_ptr;
         if (prog) begin
            acc_q  <= din[5:4];
            mode_q <= din[3:1];
            bcd_q  <= din[0];
            wr_ptr <= 1'b0;
            rd_ptr <= 1'b0;
         end
      end
   end

   // snapshots
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_pend <= 1'b0;
         cnt_hold <= '0;
         sts_pend <= 1'b0;
         sts_hold <= '0;
      end else begin
         if (rd_hit) begin
            if (sts_pend)                    sts_pend <= 1'b0;
            else if (cnt_pend && last_byte)  cnt_pend <= 1'b0;
         end
         if (snap_cnt && !cnt_pend) begin
            cnt_pend <= 1'b1;
            cnt_hold <= live;
         end
         if (snap_sts && !sts_pend) begin
            sts_pend <= 1'b1;
            sts_hold <= sts_now;
         end
      end
   end

   // R6
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_pend && $past(cnt_pend)) |-> $stable(cnt_hold));

   // R7
   sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_pend && $past(sts_pend)) |-> $stable(sts_hold));

   // R10
   ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog |=> (!wr_ptr && !rd_ptr));

endmodule

// File: rtl/timer_host_if.sv
module timer_host_if #(
   parameter int NCH = 3,
   parameter int DW  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic [1:0]       addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic [NCH*2*DW-1:0] live_cnt,
   input  logic [NCH-1:0]   out_lvl,
   output logic [NCH-1:0]   load_stb,
   output logic [NCH*2*DW-1:0] load_val,
   output logic [NCH*3-1:0] cfg_mode,
   output logic [NCH-1:0]   cfg_bcd
);
   import timer_if_pkg::*;

   localparam int CW = 2 * DW;

   if (NCH < 1 || NCH > 3) begin : g_bad_nch
      $error("timer_host_if: NCH must be 1 to 3");
   end
   if (DW != 8) begin : g_bad_dw
      $error("timer_host_if: control word layout needs DW of 8");
   end

   logic           wr_fall;
   logic           rd_fall;
   logic           cw_stb;
   logic [NCH-1:0] prog;
   logic [NCH-1:0] snap_cnt;
   logic [NCH-1:0] snap_sts;
   logic [DW-1:0]  rd_byte [NCH];
   logic [DW-1:0]  sel_byte;

   timer_strobe_edge i_wr_edge (
      .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .cs_n(cs_n), .fall(wr_fall));

   timer_strobe_edge i_rd_edge (
      .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .cs_n(cs_n), .fall(rd_fall));

   assign cw_stb = wr_fall && (addr == ADDR_CTRL);

   timer_ctrl_decode #(.NCH(NCH)) i_decode (
      .cw_stb(cw_stb), .din(wdata[7:0]),
      .prog(prog), .snap_cnt(snap_cnt), .snap_sts(snap_sts));

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      timer_chan_regs #(.DW(DW)) i_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_hit   (wr_fall && addr == 2'(i)),
         .rd_hit   (rd_fall && addr == 2'(i)),
         .prog     (prog[i]),
         .snap_cnt (snap_cnt[i]),
         .snap_sts (snap_sts[i]),
         .din      (wdata),
         .live     (live_cnt[i*CW +: CW]),
         .out_lvl  (out_lvl[i]),
         .rd_byte  (rd_byte[i]),
         .load_stb (load_stb[i]),
         .load_val (load_val[i*CW +: CW]),
         .cfg_mode (cfg_mode[i*3 +: 3]),
         .cfg_bcd  (cfg_bcd[i]));
   end

   always_comb begin
      sel_byte = '0;
      for (int i = 0; i < NCH; i++)
         if (addr == 2'(i)) sel_byte = rd_byte[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata <= '0;
      else if (rd_fall) rdata <= sel_byte;
   end

   // R2
   load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_stb));

   // R1
   load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|load_stb) |-> $past(wr_fall));

   // R1
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_fall) |-> $stable(rdata));

endmodule

// File: tb/test_timer_host_if.sv
module test_timer_host_if;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [1:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [47:0] live_cnt = '0;
   logic [2:0]  out_lvl = '0;
   logic [2:0]  load_stb;
   logic [47:0] load_val;
   logic [8:0]  cfg_mode;
   logic [2:0]  cfg_bcd;

   int checks = 0;
   int errors = 0;
   logic [2:0]  cap_stb, cap_stb2;
   logic [47:0] cap_val;
   logic [7:0]  rv;

   always #2 clk = ~clk;

   timer_host_if i_timer_host_if (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt),
      .out_lvl(out_lvl), .load_stb(load_stb), .load_val(load_val),
      .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd));

   function automatic logic [15:0] exp_load(input logic [1:0] acc,
                                            input logic [7:0] b0, b1);
      case (acc)
         2'b01:   return {8'h00, b0};
         2'b10:   return {b0, 8'h00};
         default: return {b1, b0};
      endcase
   endfunction

   function automatic logic [7:0] exp_status(input logic o, input logic [1:0] acc,
                                             input logic [2:0] m, input logic b);
      return {o, 1'b0, acc, m, b};
   endfunction

   task automatic check(input string req, input logic [31:0] got, exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic cs = 1'b1);
      @(negedge clk);
      cs_n = !cs; addr = a; wdata = d; wr_n = 1'b0;
      @(negedge clk);
      cap_stb = load_stb; cap_val = load_val;
      @(negedge clk);
      cap_stb2 = load_stb;
      wr_n = 1'b1; cs_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      cs_n = 1'b0; addr = a; rd_n = 1'b0;
      @(negedge clk);
      v = rdata;
      rd_n = 1'b1; cs_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20517));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      check("R12 rdata", rdata, 8'h00);
      check("R12 load_stb", load_stb, 3'b000);
      check("R12 cfg_mode", cfg_mode, 9'h000);
      check("R12 cfg_bcd", cfg_bcd, 3'b000);

      // R5 low-only on ch0, high-only on ch1
      wr(3, 8'h14);
      wr(0, 8'h5A);
      check("R5 lo stb", cap_stb, 3'b001);
      check("R5 lo val", cap_val[15:0], 16'h005A);
      wr(3, 8'h67);
      wr(1, 8'hC3);
      check("R5 hi stb", cap_stb, 3'b010);
      check("R5 hi val", cap_val[31:16], 16'hC300);

      // R3 programmed fields visible
      check("R3 ch0 mode", cfg_mode[2:0], 3'd2);
      check("R3 ch1 mode", cfg_mode[5:3], 3'd3);
      check("R3 bcd", cfg_bcd, 3'b010);

      // R1 strobes without chip select
      wr(3, 8'h3A, 1'b0);
      check("R1 cfg kept", cfg_mode[2:0], 3'd2);
      wr(0, 8'h44, 1'b0);
      check("R1 no load", cap_stb, 3'b000);
      live_cnt[15:0] = 16'h00E1;
      rd(0, rv);
      live_cnt[15:0] = 16'h00E2;
      @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
      @(negedge clk); rd_n = 1'b1;
      check("R1 rdata kept", rdata, 8'hE1);

      // R4 / R2 low-then-high on ch2, strobe held two cycles
      wr(3, 8'hB0);
      wr(2, 8'h34);
      check("R4 no load after low", cap_stb, 3'b000);
      wr(2, 8'h12);
      check("R4 load stb", cap_stb, 3'b100);
      check("R4 load val", cap_val[47:32], 16'h1234);
      check("R2 single pulse", cap_stb2, 3'b000);

      // R6 snapshot, then R11 live reads
      live_cnt[47:32] = 16'hBEEF;
      wr(3, 8'h80);
      live_cnt[47:32] = 16'h1111;
      rd(2, rv); check("R6 snap low", rv, 8'hEF);
      rd(2, rv); check("R6 snap high", rv, 8'hBE);
      live_cnt[47:32] = 16'h2A11;
      rd(2, rv); check("R11 live low", rv, 8'h11);
      rd(2, rv); check("R11 live high", rv, 8'h2A);

      // R7 repeated snapshot ignored
      live_cnt[47:32] = 16'h2222;
      wr(3, 8'h80);
      live_cnt[47:32] = 16'h3333;
      wr(3, 8'h80);
      live_cnt[47:32] = 16'h4444;
      rd(2, rv); check("R7 low kept", rv, 8'h22);
      rd(2, rv); check("R7 high kept", rv, 8'h22);

      // R10 pointers reset by programming
      wr(3, 8'hB0);
      wr(2, 8'h99);
      wr(3, 8'hB0);
      wr(2, 8'h78);
      check("R10 wr ptr reset", cap_stb, 3'b000);
      wr(2, 8'h56);
      check("R10 load val", cap_val[47:32], 16'h5678);
      live_cnt[47:32] = 16'hABCD;
      rd(2, rv);
      wr(3, 8'hB0);
      rd(2, rv); check("R10 rd ptr reset", rv, 8'hCD);

      // R8 read-back of status only, ch1
      out_lvl[1] = 1'b1;
      live_cnt[31:16] = 16'h5A3C;
      wr(3, 8'hE4);
      rd(1, rv); check("R8 status", rv, 8'hA7);
      rd(1, rv); check("R8 then live", rv, 8'h5A);

      // R9 status before count, ch0
      out_lvl[0] = 1'b0;
      live_cnt[15:0] = 16'h0077;
      wr(3, 8'hC2);
      live_cnt[15:0] = 16'h0011;
      wr(3, 8'hC2);
      rd(0, rv); check("R9 status first", rv, 8'h14);
      rd(0, rv); check("R9 count second", rv, 8'h77);
      rd(0, rv); check("R9 live after", rv, 8'h11);

      // R12 control address reads zero
      rd(3, rv); check("R12 addr3 read", rv, 8'h00);

      // random rounds
      for (int n = 0; n < 40; n++) begin
         int unsigned ch = $urandom_range(0, 2);
         logic [1:0]  acc = 2'($urandom_range(1, 3));
         logic [2:0]  md  = 3'($urandom_range(0, 5));
         logic        bc  = 1'($urandom_range(0, 1));
         logic [7:0]  b0  = 8'($urandom);
         logic [7:0]  b1  = 8'($urandom);
         logic [15:0] lv  = 16'($urandom);
         logic        ol  = 1'($urandom_range(0, 1));
         logic [7:0]  msk;
         wr(3, {2'(ch), acc, md, bc});
         check("R3 rand mode", cfg_mode[ch*3 +: 3], md);
         wr(2'(ch), b0);
         if (acc == 2'b11) begin
            check("R4 rand first", cap_stb, 3'b000);
            wr(2'(ch), b1);
         end
         check("R5 rand stb", cap_stb, 3'(1 << ch));
         check("R4 rand val", cap_val[ch*16 +: 16], exp_load(acc, b0, b1));
         live_cnt[ch*16 +: 16] = lv;
         wr(3, {2'(ch), 6'b000000});
         live_cnt[ch*16 +: 16] = ~lv;
         rd(2'(ch), rv);
         check("R6 rand first", rv, (acc == 2'b10) ? lv[15:8] : lv[7:0]);
         if (acc == 2'b11) begin
            rd(2'(ch), rv);
            check("R6 rand second", rv, lv[15:8]);
         end
         out_lvl[ch] = ol;
         msk = 8'(2 << ch);
         wr(3, 8'hE0 | msk);
         rd(2'(ch), rv);
         check("R8 rand status", rv, exp_status(ol, acc, md, bc));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule